// File: doc/BRIEF.md
# Bus Width Adapting Transfer Sequencer

This block sits between a 16-bit processor access port and a system bus that runs either 8 or 16 bits wide. The processor issues one access of one or two bytes. Each access carries a byte address, a direction and, for writes, a 16-bit data word. The sequencer turns that access into one or more system bus command cycles. The number of cycles depends on the bus width mode and on the alignment of the start address.

Bytes are steered onto the correct data lane. On a narrow bus, two byte reads are merged through a holding register into one 16-bit result. Every bus cycle waits for an acknowledge, and that acknowledge passes through a two-flop synchroniser before it is used. A write cycle keeps its command asserted for one extra clock so the data hold time is met.

The processor holds its request until the status line rises. It then sees a single-cycle completion pulse when the whole access is finished. A stop input keeps the sequencer from opening any new bus cycle.

Top module: `bus_width_sequencer`

## Requirements
- R1: In narrow mode (`wide_mode`=0), every byte of an access uses its own bus cycle on data lines 7:0. The upper lines are driven 0 on writes and ignored on reads. The second cycle of a two-byte access addresses start+1.
- R2: In wide mode, a one-byte access is a single byte cycle. An even address uses lines 7:0 and an odd address uses lines 15:8. The unused lane is driven 0 on writes.
- R3: In wide mode, a two-byte access from an even address is one 16-bit cycle. Processor bits 7:0 travel on bus lines 7:0 (the even byte) and bits 15:8 travel on lines 15:8.
- R4: In wide mode, a two-byte access from an odd address is two byte cycles, at start and start+1, each on the lane its own address parity selects.
- R5: `b_bhe` is 1 during 16-bit cycles and during byte cycles at odd addresses, and 0 during byte cycles at even addresses.
- R6: Read results appear on `p_rdata` at completion. A one-byte read returns its byte in bits 7:0 with bits 15:8 zero. A two-byte read returns the byte from the start address in 7:0 and the next byte in 15:8.
- R7: On a write, `b_cmd` stays high, with the address and data unchanged, through the fourth rising clock edge after `b_xack` rises, and is low after it.
- R8: On a read, `b_cmd` is low after the third rising clock edge following the rise of `b_xack`. This is two synchroniser stages plus one decision edge.
- R9: `p_stat` is 1 from acceptance of an access until its completion and 0 afterwards. `p_done` is a single-cycle pulse at completion.
- R10: While `stop_rq` is 1, no bus cycle starts and a pending request is not accepted. Once it is released, the held request proceeds normally.
- R11: After reset, `b_cmd`, `p_done` and `p_stat` are 0 and `p_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1: 16-bit system bus, 0: 8-bit system bus |
| stop_rq | input | 1 | Blocks new bus cycles while high |
| p_req | input | 1 | Processor request, held until `p_stat` rises |
| p_addr | input | AW | Byte start address |
| p_dbl | input | 1 | 1: two-byte access, 0: one byte |
| p_write | input | 1 | 1: write, 0: read |
| p_wdata | input | 16 | Write data, first byte in bits 7:0 |
| p_rdata | output | 16 | Assembled read data |
| p_done | output | 1 | One-cycle completion pulse |
| p_stat | output | 1 | Access in progress; 0 after an error-free completion |
| b_cmd | output | 1 | Bus command active |
| b_write | output | 1 | Bus cycle direction |
| b_addr | output | AW | Bus byte address |
| b_bhe | output | 1 | High byte lane enable |
| b_dout | output | 16 | Bus write data |
| b_din | input | 16 | Bus read data |
| b_xack | input | 1 | Asynchronous bus acknowledge |

## Verification
Accesses are run in every combination of bus width, byte count, address parity and direction. Narrow-mode double accesses separate the merge path from the word path. Wide-mode odd-start doubles show that alignment, and not the byte count alone, selects split cycles. Single-byte cases at even and odd addresses expose lane and high-byte-enable errors.

Read data from the bus model places filler on the unused lane, so a wrong lane select returns a visibly wrong byte. The edge count from acknowledge to command release tells a read apart from a stretched write. A stalled request under the stop input shows that no cycle leaks out.

// File: rtl/bus_width_sequencer.sv
module bus_width_sequencer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          stop_rq,
  input  logic          p_req,
  input  logic [AW-1:0] p_addr,
  input  logic          p_dbl,
  input  logic          p_write,
  input  logic [15:0]   p_wdata,
  output logic [15:0]   p_rdata,
  output logic          p_done,
  output logic          p_stat,
  output logic          b_cmd,
  output logic          b_write,
  output logic [AW-1:0] b_addr,
  output logic          b_bhe,
  output logic [15:0]   b_dout,
  input  logic [15:0]   b_din,
  input  logic          b_xack
);
  typedef enum logic [1:0] {S_IDLE, S_CMD, S_HOLD, S_REL} st_t;
  st_t st;

  logic [AW-1:0] base_q;
  logic          dbl_q, wr_q, wide_q, cnt_q, xs1, xs2;
  logic [15:0]   wdata_q, asm_q;

  logic          word_c, last_c, lane_hi;
  logic [AW-1:0] cur_addr;
  logic [7:0]    wbyte, rbyte;

  assign word_c   = wide_q && dbl_q && !base_q[0];
  assign cur_addr = base_q + AW'(cnt_q);
  assign last_c   = word_c || !dbl_q || cnt_q;
  assign lane_hi  = wide_q && cur_addr[0];
  assign wbyte    = cnt_q ? wdata_q[15:8] : wdata_q[7:0];
  assign rbyte    = lane_hi ? b_din[15:8] : b_din[7:0];

  assign b_cmd   = (st == S_CMD) || (st == S_HOLD);
  assign b_write = wr_q;
  assign b_addr  = cur_addr;
  assign b_bhe   = b_cmd && (word_c || cur_addr[0]);
  assign b_dout  = word_c ? wdata_q : (lane_hi ? {wbyte, 8'h00} : {8'h00, wbyte});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      dbl_q   <= 1'b0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      cnt_q   <= 1'b0;
      xs1     <= 1'b0;
      xs2     <= 1'b0;
      wdata_q <= '0;
      asm_q   <= '0;
      p_rdata <= '0;
      p_done  <= 1'b0;
      p_stat  <= 1'b0;
    end else begin
      xs1    <= b_xack;
      xs2    <= xs1;
      p_done <= 1'b0;
      case (st)
        S_IDLE: if (p_req && !stop_rq) begin
          base_q  <= p_addr;
          dbl_q   <= p_dbl;
          wr_q    <= p_write;
          wdata_q <= p_wdata;
          wide_q  <= wide_mode;
          cnt_q   <= 1'b0;
          p_stat  <= 1'b1;
          st      <= S_CMD;
        end
        S_CMD: if (xs2) begin
          if (wr_q) st <= S_HOLD;
          else begin
            if (word_c)     asm_q        <= b_din;
            else if (cnt_q) asm_q[15:8]  <= rbyte;
            else            asm_q        <= {8'h00, rbyte};
            st <= S_REL;
          end
        end
        S_HOLD: st <= S_REL;
        S_REL: if (!xs2) begin
          if (last_c) begin
            st     <= S_IDLE;
            p_done <= 1'b1;
            p_stat <= 1'b0;
            if (!wr_q) p_rdata <= asm_q;
          end else if (!stop_rq) begin
            cnt_q <= 1'b1;
            st    <= S_CMD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && xs2 && wr_q) |=> (b_cmd && $stable(b_dout) && $stable(b_addr)));

  assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && xs2 && !wr_q) |=> !b_cmd);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    p_done |=> !p_done);

  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_done) |-> ($past(p_stat) && !p_stat));

  assert_stop_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cmd && stop_rq) |=> !b_cmd);

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_cmd && $past(b_cmd)) |-> $stable(b_addr));
endmodule

// File: tb/bus_width_sequencer_test.sv
module bus_width_sequencer_test;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0, stop_rq = 1'b0, p_req = 1'b0, p_dbl = 1'b0, p_write = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [15:0] p_wdata = '0, b_din = '0;
  logic b_xack = 1'b0;
  logic [15:0] p_rdata, b_dout;
  logic p_done, p_stat, b_cmd, b_write, b_bhe;
  logic [AW-1:0] b_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_width_sequencer #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .stop_rq(stop_rq),
    .p_req(p_req), .p_addr(p_addr), .p_dbl(p_dbl), .p_write(p_write),
    .p_wdata(p_wdata), .p_rdata(p_rdata), .p_done(p_done), .p_stat(p_stat),
    .b_cmd(b_cmd), .b_write(b_write), .b_addr(b_addr), .b_bhe(b_bhe),
    .b_dout(b_dout), .b_din(b_din), .b_xack(b_xack)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    logic          bhe;
    logic [15:0]   dout;
    logic [15:0]   din;
    string         tag;
  } cyc_t;
  cyc_t exp_q[$];

  function automatic logic [7:0] memb(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Bus monitor and responder: pops one expected cycle per command
  initial begin
    forever begin
      @(negedge clk);
      if (b_cmd) begin
        cyc_t e;
        int edges;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected bus cycle at addr", 32'(b_addr), 32'hFFFF);
          e.din = 16'h0; e.wr = b_write; e.tag = "R10";
        end else begin
          e = exp_q.pop_front();
          chk(b_addr == e.addr, e.tag, "bus address", 32'(b_addr), 32'(e.addr));
          chk(b_write == e.wr, e.tag, "bus direction", 32'(b_write), 32'(e.wr));
          chk(b_bhe == e.bhe, "R5", "high byte enable", 32'(b_bhe), 32'(e.bhe));
          if (e.wr) chk(b_dout == e.dout, e.tag, "bus write data", 32'(b_dout), 32'(e.dout));
        end
        b_din  = e.din;
        b_xack = 1'b1;
        edges  = 0;
        while (1) begin
          @(posedge clk);
          edges++;
          @(negedge clk);
          if (!b_cmd || edges > 20) break;
        end
        if (e.wr) chk(edges == 4, "R7", "edges from ack to release (write)", 32'(edges), 32'd4);
        else      chk(edges == 3, "R8", "edges from ack to release (read)", 32'(edges), 32'd3);
        b_xack = 1'b0;
        b_din  = 16'hDEAD;
      end
    end
  end

  task automatic access(input logic wide, input logic [AW-1:0] a, input logic dbl,
                        input logic wr, input logic [15:0] wd, input string tag,
                        input int stall);
    bit word;
    int n;
    logic [15:0] exp_rd;
    int waitc;
    word = wide && dbl && !a[0];
    n = word ? 1 : (dbl ? 2 : 1);
    for (int k = 0; k < n; k++) begin
      cyc_t e;
      logic [AW-1:0] ca;
      logic [7:0] wb;
      logic hi;
      ca = a + AW'(k);
      wb = (k == 1) ? wd[15:8] : wd[7:0];
      hi = wide && ca[0];
      e.addr = ca; e.wr = wr; e.tag = tag;
      if (word) begin
        e.bhe = 1'b1; e.dout = wd; e.din = {memb(a + 1'b1), memb(a)};
      end else begin
        e.bhe  = ca[0];
        e.dout = hi ? {wb, 8'h00} : {8'h00, wb};
        e.din  = hi ? {memb(ca), 8'hC3} : {8'hC3, memb(ca)};
      end
      exp_q.push_back(e);
    end
    exp_rd = dbl ? {memb(a + 1'b1), memb(a)} : {8'h00, memb(a)};

    @(negedge clk);
    wide_mode = wide; p_addr = a; p_dbl = dbl; p_write = wr; p_wdata = wd;
    if (stall > 0) begin
      bit seen;
      stop_rq = 1'b1;
      p_req = 1'b1;
      seen = 1'b0;
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        if (b_cmd || p_stat) seen = 1'b1;
      end
      chk(!seen, "R10", "activity while stopped", 32'(seen), 32'd0);
      stop_rq = 1'b0;
    end
    p_req = 1'b1;
    @(negedge clk);
    chk(p_stat == 1'b1, "R9", "status after accept", 32'(p_stat), 32'd1);
    p_req = 1'b0;
    waitc = 0;
    while (!p_done && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    chk(p_done == 1'b1, "R9", "completion pulse", 32'(p_done), 32'd1);
    chk(p_stat == 1'b0, "R9", "status after completion", 32'(p_stat), 32'd0);
    if (!wr) chk(p_rdata == exp_rd, tag, "assembled read data (R6)", 32'(p_rdata), 32'(exp_rd));
    chk(exp_q.size() == 0, tag, "missing bus cycles", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    @(negedge clk);
    chk(p_done == 1'b0, "R9", "done is one cycle", 32'(p_done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(b_cmd == 1'b0, "R11", "cmd after reset", 32'(b_cmd), 32'd0);
    chk(p_done == 1'b0, "R11", "done after reset", 32'(p_done), 32'd0);
    chk(p_stat == 1'b0, "R11", "status after reset", 32'(p_stat), 32'd0);
    chk(p_rdata == 16'h0, "R11", "rdata after reset", 32'(p_rdata), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    access(1'b0, 16'h0010, 1'b1, 1'b0, 16'h0000, "R1", 0);   // narrow merge read (R6)
    access(1'b0, 16'h0021, 1'b1, 1'b1, 16'hA5B6, "R1", 0);   // narrow write, odd start
    access(1'b0, 16'h0033, 1'b0, 1'b0, 16'h0000, "R1", 0);   // narrow single read
    access(1'b1, 16'h0040, 1'b0, 1'b0, 16'h0000, "R2", 0);   // wide even byte read
    access(1'b1, 16'h0041, 1'b0, 1'b0, 16'h0000, "R2", 0);   // wide odd byte read
    access(1'b1, 16'h0043, 1'b0, 1'b1, 16'h1177, "R2", 0);   // wide odd byte write
    access(1'b1, 16'h0050, 1'b1, 1'b0, 16'h0000, "R3", 0);   // wide word read
    access(1'b1, 16'h0052, 1'b1, 1'b1, 16'hC0DE, "R3", 0);   // wide word write
    access(1'b1, 16'h0061, 1'b1, 1'b0, 16'h0000, "R4", 0);   // wide odd double read
    access(1'b1, 16'h0063, 1'b1, 1'b1, 16'h9A8B, "R4", 0);   // wide odd double write
    access(1'b1, 16'h0070, 1'b1, 1'b0, 16'h0000, "R10", 20); // stalled by stop

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule